// File: doc/BRIEF.md
# Banked Associative-Tag Cache Controller

This block is the lookup and refill controller of a 4 KB cache that holds instructions and data together and is indexed by virtual address. The tag store is split into four banks of 64 lines, and each line holds four 32-bit words. Within a bank every line is a candidate, so a lookup compares the request tag against all 64 stored tags at once. Two address bits choose the one bank that is searched on a request. The stored tag combines the upper address bits with a 3-bit access/control field. Two bits of that field let the same virtual address be kept apart for user and supervisor mappings.

A read that hits returns the word from a 1024 x 32 data array. The array address is the matching line number, then the bank number, then the word number. A read that misses evicts a pseudo-randomly chosen line of the selected bank. It then fetches the four words of the line from memory in order and returns the requested word as soon as it arrives. Writes always go to memory. A write that hits also updates the cached word, and a write that misses does not allocate a line. A flush request invalidates every line in one cycle.

The controller is a four-state machine:
- IDLE: it waits here for work. It goes to LOOKUP when `req_valid` is high and `flush_req` is low. It stays in IDLE, clearing every valid bit, when `flush_req` is high.
- LOOKUP: it searches the selected bank. A read hit goes back to IDLE. A read miss goes to FILL. Any write goes to WRMEM.
- FILL: it fetches the line, one beat per `mem_rd_valid`. After the fourth beat it goes to IDLE.
- WRMEM: it holds the memory write until `mem_wr_ack`, then goes to IDLE.

Top module: `banked_cam_cache`

## Requirements
- R1: After reset `busy`, `rsp_valid`, `mem_rd_req` and `mem_wr_req` are low, and every line is invalid, so the first read of any address misses.
- R2: A read miss issues exactly four memory reads. They go to the line base address (request address with bits [3:0] cleared), then base+4, base+8 and base+12, in that order, one per accepted `mem_rd_valid` beat.
- R3: On a read miss the response carries the memory word at the request address with `rsp_hit` low. Address bits [1:0] have no effect on which word is returned.
- R4: Once a line has been filled, a read of any of its four words hits. It returns the cached word with `rsp_hit` high and no memory read, and `rsp_valid` rises on the second clock edge after the request is accepted.
- R5: Address bits [5:4] choose the bank, and bits [3:2] choose the word. Lines that differ only in bits [5:4] sit in different banks and can be cached together. Filling one bank never evicts a line of another bank.
- R6: The 3-bit `req_ctl` field is part of the tag. A read with a cached address but a different `req_ctl` value misses.
- R7: A word write that hits updates the cached word and issues one memory write with byte enables 4'b1111 and the request data. The response has `rsp_hit` high.
- R8: A byte write (`req_byte` high) uses byte enable bit `req_addr[1:0]` only and puts `req_wdata[7:0]` in every byte lane of `mem_wr_data`. On a hit only that byte of the cached word changes.
- R9: A write miss issues one memory write and no memory read, and it responds with `rsp_hit` low. The line is not allocated, so a later read of it misses and returns the written data from memory.
- R10: A flush invalidates every line in one cycle. A read after a flush misses even if its line was cached before.
- R11: When `flush_req` and `req_valid` are both high in IDLE, the flush is performed and the request is dropped. No response and no memory traffic follow.
- R12: A write holds `mem_wr_req`, its address and its data until `mem_wr_ack`. The response is given on the clock edge after the acknowledge, and `busy` stays high until then.
- R13: The victim line of a read miss comes from a 6-bit sequence that advances once per miss. Any 64 consecutive misses in one bank use 64 different lines of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_req | input | 1 | Invalidate all lines (sampled in IDLE) |
| req_valid | input | 1 | Request strobe (sampled in IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte write, 0 = word write |
| req_addr | input | 32 | Virtual byte address |
| req_ctl | input | 3 | Access/control bits stored with the tag |
| req_wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| busy | output | 1 | High while a request is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| mem_rd_req | output | 1 | Line-fill read request |
| mem_rd_addr | output | 32 | Line-fill word address |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_data | input | 32 | Read beat data |
| mem_wr_req | output | 1 | Write-through request |
| mem_wr_addr | output | 32 | Write word address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
A wrong valid bit or a wrong stored tag shows up at the ports on the next read of that line. A line that was lost costs four extra memory reads, and `rsp_valid` comes late instead of on the second edge. A line that should be gone, after a flush or after a change of `req_ctl`, instead gives a hit with no memory traffic. A data array word written at the wrong address, from the wrong line number, bank or word field, gives wrong `rsp_rdata` on the first later hit to either address. A victim sequence that repeats a line within 64 misses drops the number of hits when a bank is re-read after 100 fills.

// File: rtl/bcc_pkg.sv
`timescale 1ns/1ps
package bcc_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2,
        ST_WRMEM  = 2'd3
    } bcc_state_t;

endpackage

// File: rtl/bcc_tag_bank.sv
`timescale 1ns/1ps
module bcc_tag_bank #(
    parameter int LINES = 64,
    parameter int TAG_W = 29,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             search_en,
    input  logic [TAG_W-1:0] search_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] match_vec;

    always_ff @(posedge clk) begin
        if (load_en) begin
            tag_q[load_idx] <= load_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else begin
            if (load_en) begin
                valid_q[load_idx] <= 1'b0;
            end
            if (mark_en) begin
                valid_q[mark_idx] <= 1'b1;
            end
        end
    end

    // Parallel compare of every entry against the key
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            match_vec[i] = search_en & valid_q[i] & (tag_q[i] == search_tag);
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
    end

    assign hit = |match_vec;

    // R5
    cam_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

endmodule

// File: rtl/bcc_victim_gen.sv
`timescale 1ns/1ps
module bcc_victim_gen #(
    parameter int          W    = 6,
    parameter logic [W-1:0] TAPS = 6'b110000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);

    logic [W-1:0] seq_q;
    logic         fb;

    // Shift register extended with the all-zero state: full 2**W cycle
    assign fb = (^(seq_q & TAPS)) ^ (seq_q[W-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= W'(1);
        end else if (step) begin
            seq_q <= {seq_q[W-2:0], fb};
        end
    end

    assign value = seq_q;

    // R13
    victim_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (value != $past(value)));

endmodule

// File: rtl/bcc_data_ram.sv
`timescale 1ns/1ps
module bcc_data_ram #(
    parameter int AW = 10,
    parameter int DW = 32,
    localparam int BE_W  = DW / 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [BE_W-1:0] wbe,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < BE_W; l++) begin
                if (wbe[l]) begin
                    mem_q[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/banked_cam_cache.sv
`timescale 1ns/1ps
module banked_cam_cache
    import bcc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CTL_W      = 3,
    parameter int N_BANKS    = 4,
    parameter int BANK_LINES = 64,
    parameter int LINE_WORDS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_req,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_byte,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [CTL_W-1:0]      req_ctl,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  busy,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [DATA_W-1:0]     mem_wr_data,
    output logic [DATA_W/8-1:0]   mem_wr_be,
    input  logic                  mem_wr_ack
);

    localparam int BE_W       = DATA_W / 8;
    localparam int BYTE_OFF_W = $clog2(BE_W);
    localparam int WORD_SEL_W = $clog2(LINE_WORDS);
    localparam int BANK_SEL_W = $clog2(N_BANKS);
    localparam int IDX_W      = $clog2(BANK_LINES);
    localparam int LINE_LO    = BYTE_OFF_W + WORD_SEL_W;
    localparam int TAG_LO     = LINE_LO + BANK_SEL_W;
    localparam int TAG_W      = ADDR_W - TAG_LO + CTL_W;
    localparam int RAM_AW     = IDX_W + BANK_SEL_W + WORD_SEL_W;
    localparam logic [WORD_SEL_W-1:0] LAST_BEAT = WORD_SEL_W'(LINE_WORDS - 1);

    // ---------------- registers ----------------
    bcc_state_t                 state_q, state_d;
    logic [ADDR_W-1:BYTE_OFF_W] addr_q;
    logic [CTL_W-1:0]           ctl_q;
    logic [DATA_W-1:0]          wdata_q;
    logic [BE_W-1:0]            be_q;
    logic                       write_q;
    logic                       wr_hit_q;
    logic [IDX_W-1:0]           fill_idx_q;
    logic [WORD_SEL_W-1:0]      beat_q;

    // ---------------- address fields ----------------
    logic [WORD_SEL_W-1:0] word_sel;
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [TAG_W-1:0]      tag_key;

    assign word_sel = addr_q[BYTE_OFF_W +: WORD_SEL_W];
    assign bank_sel = addr_q[LINE_LO +: BANK_SEL_W];
    assign tag_key  = {addr_q[ADDR_W-1:TAG_LO], ctl_q};

    // ---------------- request shaping ----------------
    logic [BE_W-1:0]   req_be;
    logic [DATA_W-1:0] req_wd;

    assign req_be = req_byte ? (BE_W'(1) << req_addr[BYTE_OFF_W-1:0]) : {BE_W{1'b1}};
    assign req_wd = req_byte ? {BE_W{req_wdata[7:0]}} : req_wdata;

    // ---------------- control strobes ----------------
    logic             do_flush, do_accept;
    logic             search_en, load_en, mark_en, beat_take;
    logic             lookup_hit;
    logic [IDX_W-1:0] lookup_idx;
    logic [IDX_W-1:0] victim_idx;

    // ---------------- banks ----------------
    logic [N_BANKS-1:0] bank_hit;
    logic [IDX_W-1:0]   bank_idx [N_BANKS];

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            logic sel_this;
            assign sel_this = (bank_sel == BANK_SEL_W'(b));
            bcc_tag_bank #(
                .LINES (BANK_LINES),
                .TAG_W (TAG_W)
            ) u_tag_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush_all  (do_flush),
                .search_en  (search_en & sel_this),
                .search_tag (tag_key),
                .hit        (bank_hit[b]),
                .hit_idx    (bank_idx[b]),
                .load_en    (load_en & sel_this),
                .load_idx   (victim_idx),
                .load_tag   (tag_key),
                .mark_en    (mark_en & sel_this),
                .mark_idx   (fill_idx_q)
            );
        end
    endgenerate

    assign lookup_hit = bank_hit[bank_sel];
    assign lookup_idx = bank_idx[bank_sel];

    bcc_victim_gen #(
        .W    (IDX_W),
        .TAPS (IDX_W'(6'b110000))
    ) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (load_en),
        .value (victim_idx)
    );

    // ---------------- data array ----------------
    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr, ram_raddr;
    logic [BE_W-1:0]   ram_wbe;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;

    assign ram_raddr = {lookup_idx, bank_sel, word_sel};

    bcc_data_ram #(
        .AW (RAM_AW),
        .DW (DATA_W)
    ) u_data (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wbe   (ram_wbe),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush_req && req_valid) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (write_q) begin
                    state_d = ST_WRMEM;
                end else if (lookup_hit) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rd_valid && beat_q == LAST_BEAT) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRMEM: begin
                if (mem_wr_ack) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // ---------------- outputs / strobes ----------------
    always_comb begin
        do_flush   = 1'b0;
        do_accept  = 1'b0;
        search_en  = 1'b0;
        load_en    = 1'b0;
        mark_en    = 1'b0;
        beat_take  = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        ram_we     = 1'b0;
        ram_waddr  = {lookup_idx, bank_sel, word_sel};
        ram_wbe    = be_q;
        ram_wdata  = wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                do_flush  = flush_req;
                do_accept = !flush_req && req_valid;
            end
            ST_LOOKUP: begin
                search_en = 1'b1;
                load_en   = !write_q && !lookup_hit;
                ram_we    = write_q && lookup_hit;
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                beat_take  = mem_rd_valid;
                mark_en    = mem_rd_valid && (beat_q == LAST_BEAT);
                ram_we     = mem_rd_valid;
                ram_waddr  = {fill_idx_q, bank_sel, beat_q};
                ram_wbe    = {BE_W{1'b1}};
                ram_wdata  = mem_rd_data;
            end
            ST_WRMEM: begin
                mem_wr_req = 1'b1;
            end
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign mem_rd_addr = {addr_q[ADDR_W-1:LINE_LO], beat_q, {BYTE_OFF_W{1'b0}}};
    assign mem_wr_addr = {addr_q, {BYTE_OFF_W{1'b0}}};
    assign mem_wr_data = wdata_q;
    assign mem_wr_be   = be_q;

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            ctl_q      <= '0;
            wdata_q    <= '0;
            be_q       <= '0;
            write_q    <= 1'b0;
            wr_hit_q   <= 1'b0;
            fill_idx_q <= '0;
            beat_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (do_accept) begin
                addr_q  <= req_addr[ADDR_W-1:BYTE_OFF_W];
                ctl_q   <= req_ctl;
                wdata_q <= req_wd;
                be_q    <= req_be;
                write_q <= req_write;
            end
            if (search_en) begin
                if (write_q) begin
                    wr_hit_q <= lookup_hit;
                end else if (lookup_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_rdata <= ram_rdata;
                end else begin
                    fill_idx_q <= victim_idx;
                    beat_q     <= '0;
                end
            end
            if (beat_take) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == word_sel) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_rdata <= mem_rd_data;
                end
            end
            if (mem_wr_req && mem_wr_ack) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= wr_hit_q;
                rsp_rdata <= '0;
            end
        end
    end

    // ---------------- assertions ----------------
    // R2
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid && mem_rd_addr[BYTE_OFF_W +: WORD_SEL_W] != LAST_BEAT)
        |=> (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(BE_W)));

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R9
    one_mem_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R11
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !busy) |=> (!busy && !rsp_valid));

endmodule

// File: tb/banked_cam_cache_bench.sv
`timescale 1ns/1ps
module banked_cam_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_req = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_ctl = 3'b001;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;
    logic        mem_rd_req, mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_addr, mem_rd_data = '0;
    logic        mem_wr_req, mem_wr_ack = 1'b0;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_be;

    banked_cam_cache u_banked_cam_cache (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .req_valid(req_valid),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_ctl(req_ctl), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_err = 0;
    int rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0;
    int wr_delay = 0, wr_wait = 0;
    logic [31:0] rd_log [$];
    logic [31:0] last_wr_addr, last_wr_data;
    logic [3:0]  last_wr_be;
    logic [31:0] store [int unsigned];

    function automatic logic [31:0] dflt(input logic [29:0] w);
        return {w[13:0], 2'b10, w[15:0]} ^ 32'hC3A5_0F69;
    endfunction

    function automatic logic [31:0] mem_get(input logic [29:0] w);
        if (store.exists(int'(w))) return store[int'(w)];
        return dflt(w);
    endfunction

    // Memory model, driven away from the active edge
    always @(negedge clk) begin
        if (mem_rd_req) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem_get(mem_rd_addr[31:2]);
            rd_log.push_back(mem_rd_addr);
            rd_cnt++;
        end else begin
            mem_rd_valid = 1'b0;
        end
        if (mem_wr_req) begin
            if (wr_wait >= wr_delay) begin
                logic [31:0] cur;
                cur = mem_get(mem_wr_addr[31:2]);
                for (int b = 0; b < 4; b++)
                    if (mem_wr_be[b]) cur[b*8 +: 8] = mem_wr_data[b*8 +: 8];
                store[int'(mem_wr_addr[31:2])] = cur;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
                last_wr_be   = mem_wr_be;
                wr_cnt++;
                mem_wr_ack = 1'b1;
                wr_wait = 0;
            end else begin
                mem_wr_ack = 1'b0;
                wr_wait++;
            end
        end else begin
            mem_wr_ack = 1'b0;
            wr_wait = 0;
        end
        if (rsp_valid) rsp_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input bit byt, input logic [31:0] addr,
                          input logic [2:0] ctl, input logic [31:0] wd,
                          output logic [31:0] rd, output logic hit, output int lat);
        int guard;
        while (busy) @(negedge clk);
        req_write = wr; req_byte = byt; req_addr = addr; req_ctl = ctl; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        guard = 0;
        while (!rsp_valid && guard < 1000) begin
            @(negedge clk);
            lat++;
            guard++;
        end
        rd = rsp_rdata;
        hit = rsp_hit;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic do_flush();
        while (busy) @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        @(negedge clk);
    endtask

    logic [31:0] rd;
    logic        hit;
    int          lat;
    int          rd0, wr0;

    task automatic t_reset();
        chk(busy == 0, "R1", "busy", 32'(busy), 0);
        chk(rsp_valid == 0, "R1", "rsp_valid", 32'(rsp_valid), 0);
        chk(mem_rd_req == 0 && mem_wr_req == 0, "R1", "mem req", {mem_rd_req, mem_wr_req}, 0);
    endtask

    task automatic t_read_miss();
        rd_log.delete();
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_123B, 3'b001, 0, rd, hit, lat);
        chk(hit == 0, "R1", "first read hit", 32'(hit), 0);
        chk(rd_cnt - rd0 == 4, "R2", "fill beats", rd_cnt - rd0, 4);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = (i < rd_log.size()) ? rd_log[i] : 32'hFFFF_FFFF;
            chk(a == 32'h1230 + 32'(4 * i), "R2", "fill addr", a, 32'h1230 + 32'(4 * i));
        end
        chk(rd == dflt(30'h48E), "R3", "miss data", rd, dflt(30'h48E));
    endtask

    task automatic t_read_hits();
        for (int w = 0; w < 4; w++) begin
            logic [31:0] a;
            a = 32'h1230 + 32'(4 * w) + 32'(w);  // low bits vary and are ignored (R3)
            rd0 = rd_cnt;
            do_req(0, 0, a, 3'b001, 0, rd, hit, lat);
            chk(hit == 1 && rd_cnt == rd0, "R4", "hit no fetch", {hit, 31'(rd_cnt - rd0)}, 32'h8000_0000);
            chk(rd == dflt(a[31:2]), "R4", "hit data", rd, dflt(a[31:2]));
            chk(lat == 2, "R4", "hit latency", lat, 2);
        end
    endtask

    task automatic t_ctl_tag();
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_1238, 3'b101, 0, rd, hit, lat);
        chk(hit == 0 && rd_cnt - rd0 == 4, "R6", "other ctl miss", rd_cnt - rd0, 4);
    endtask

    task automatic t_write_hit();
        wr0 = wr_cnt; rd0 = rd_cnt;
        do_req(1, 0, 32'h0000_1234, 3'b001, 32'hDEAD_BEEF, rd, hit, lat);
        chk(wr_cnt - wr0 == 1 && hit == 1, "R7", "write hit count", wr_cnt - wr0, 1);
        chk(last_wr_addr == 32'h1234 && last_wr_be == 4'hF, "R7", "write addr/be",
            {last_wr_addr[27:0], last_wr_be}, {28'h1234, 4'hF});
        chk(last_wr_data == 32'hDEAD_BEEF, "R7", "write data", last_wr_data, 32'hDEAD_BEEF);
        do_req(0, 0, 32'h0000_1234, 3'b001, 0, rd, hit, lat);
        chk(hit == 1 && rd == 32'hDEAD_BEEF && rd_cnt == rd0, "R7", "read after write", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_byte_write();
        logic [31:0] exp;
        exp = (dflt(30'h48C) & 32'hFF00_FFFF) | 32'h005E_0000;
        do_req(1, 1, 32'h0000_1232, 3'b001, 32'h1234_565E, rd, hit, lat);
        chk(last_wr_be == 4'b0100, "R8", "byte be", 32'(last_wr_be), 32'h4);
        chk(last_wr_data == 32'h5E5E_5E5E, "R8", "byte lanes", last_wr_data, 32'h5E5E_5E5E);
        do_req(0, 0, 32'h0000_1230, 3'b001, 0, rd, hit, lat);
        chk(hit == 1 && rd == exp, "R8", "merged word", rd, exp);
    endtask

    task automatic t_write_miss();
        rd0 = rd_cnt; wr0 = wr_cnt;
        do_req(1, 0, 32'h0000_8004, 3'b001, 32'h1357_9BDF, rd, hit, lat);
        chk(rd_cnt == rd0 && wr_cnt - wr0 == 1 && hit == 0, "R9", "write miss traffic",
            {rd_cnt - rd0, 1'b0}, 32'h0);
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_8004, 3'b001, 0, rd, hit, lat);
        chk(hit == 0 && rd_cnt - rd0 == 4, "R9", "no allocate", rd_cnt - rd0, 4);
        chk(rd == 32'h1357_9BDF, "R9", "memory data", rd, 32'h1357_9BDF);
    endtask

    task automatic t_write_ack();
        wr_delay = 3;
        do_req(1, 0, 32'h0000_1238, 3'b001, 32'hA0A0_0505, rd, hit, lat);
        chk(lat == 6, "R12", "write ack wait", lat, 6);
        wr_delay = 0;
        do_req(1, 0, 32'h0000_1238, 3'b001, 32'hA0A0_0606, rd, hit, lat);
        chk(lat == 3, "R12", "write no wait", lat, 3);
    endtask

    task automatic t_flush();
        do_req(0, 0, 32'h0000_1238, 3'b001, 0, rd, hit, lat);
        chk(hit == 1, "R10", "hit before flush", 32'(hit), 1);
        do_flush();
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_1238, 3'b001, 0, rd, hit, lat);
        chk(hit == 0 && rd_cnt - rd0 == 4, "R10", "miss after flush", rd_cnt - rd0, 4);
    endtask

    task automatic t_flush_prio();
        int r0;
        do_req(0, 0, 32'h0000_2000, 3'b001, 0, rd, hit, lat);
        while (busy) @(negedge clk);
        r0 = rsp_cnt; rd0 = rd_cnt; wr0 = wr_cnt;
        flush_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000;
        @(negedge clk);
        flush_req = 1'b0; req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(rsp_cnt == r0 && rd_cnt == rd0 && wr_cnt == wr0, "R11", "request dropped",
            rsp_cnt - r0 + rd_cnt - rd0, 0);
        chk(busy == 0, "R11", "idle after flush", 32'(busy), 0);
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_2000, 3'b001, 0, rd, hit, lat);
        chk(hit == 0 && rd_cnt - rd0 == 4, "R11", "flushed line misses", rd_cnt - rd0, 4);
    endtask

    task automatic t_banks();
        int hits;
        do_flush();
        do_req(0, 0, 32'h0000_0400, 3'b001, 0, rd, hit, lat);
        for (int i = 0; i < 100; i++)
            do_req(0, 0, (32'(i + 16) << 6) | 32'h10, 3'b001, 0, rd, hit, lat);
        hits = 0;
        for (int i = 99; i >= 0; i--) begin
            do_req(0, 0, (32'(i + 16) << 6) | 32'h10, 3'b001, 0, rd, hit, lat);
            if (hit) hits++;
        end
        chk(hits == 64, "R13", "survivors after 100 fills", hits, 64);
        rd0 = rd_cnt;
        do_req(0, 0, 32'h0000_0400, 3'b001, 0, rd, hit, lat);
        chk(hit == 1 && rd_cnt == rd0, "R5", "other bank untouched", 32'(hit), 1);
        chk(rd == dflt(30'h100), "R5", "other bank data", rd, dflt(30'h100));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hits();
        t_ctl_tag();
        t_write_hit();
        t_byte_write();
        t_write_miss();
        t_write_ack();
        t_flush();
        t_flush_prio();
        t_banks();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule